// File: doc/BRIEF.md
# Flash Programming Sequencer

This block acts as the programming station for a byte-wide, electrically erasable, many-time programmable flash. On a start command it erases the whole array with one long write-enable pulse under two high-voltage requests, then reads every location back and insists on FFh. It then walks the address range from zero upward. For each address it fetches the byte to write from an upstream source over a request/valid handshake, applies one short program pulse under the output-enable high-voltage request, and reads the location back in normal mode to compare it with the fetched byte.

Before the erase it can optionally read the two identifier bytes. This read holds the address-line high-voltage request and toggles address bit 0. A wrong manufacturer byte stops the run. Every failure ends in a terminal error state that releases the flash and reports a code and the failing address. Pulse widths are derived from a clock-frequency parameter: the program pulse is 10 µs and the erase pulse is 100 ms, each rounded down to whole cycles with a minimum of one. Setup, hold and read-settle margins are given in cycles.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset and in the idle state, flashCeN, flashOeN and flashWeN are 1, hvOeReq, hvAddrReq and flashDqOe are 0, and busy, done and err are 0.
- R2: With readIdFirst set at start, the block reads with hvAddrReq=1 and flashAddr=0, then flashAddr=1, and presents the bytes on idMfr and idDev. If idMfr is not BFh it enters the error state with errCode=1 and issues no write-enable pulse.
- R3: The erase asserts hvOeReq and hvAddrReq with flashCeN low and drives exactly one flashWeN low pulse of CLK_HZ/10 cycles. Both high-voltage requests stay unchanged while flashWeN is low and for the cycle after it rises.
- R4: After the erase every address from 0 to the last is read in normal mode (hvOeReq=hvAddrReq=0, flashOeN=0). The first byte that is not FFh gives errCode=2 with errAddr set to that address, and no program pulse follows.
- R5: Programming goes through the addresses in ascending order. For each one the block raises srcReq with srcAddr equal to the address and waits for a srcValid pulse that carries srcData. It then drives one flashWeN low pulse of CLK_HZ/100000 cycles (minimum 1) with hvOeReq=1 and hvAddrReq=0.
- R6: flashAddr and flashDqOut are unchanged for at least SETUP_CYC cycles before flashWeN falls, for the whole low phase, and for the cycle after it rises.
- R7: After each program pulse the location is read back in normal mode. A byte that differs from srcData gives errCode=3 with errAddr set to that address, and no further pulse follows.
- R8: When the last address verifies, done=1, err=0, busy=0 and errCode=0 until the next start. done and err are never high together.
- R9: In the error state err=1, busy=0, and the flash pins are released as in R1.
- R10: flashWeN is low only while flashCeN is low, and flashDqOe is high only while flashOeN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; accepted only when not busy |
| readIdFirst | input | 1 | Read identifier bytes before erasing |
| srcValid | input | 1 | One-cycle pulse: srcData holds the byte for srcAddr |
| srcData | input | 8 | Byte to program |
| flashDqIn | input | 8 | Data read from the flash |
| srcReq | output | 1 | Request for the byte at srcAddr |
| srcAddr | output | ADDR_W | Address of the requested byte |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashWeN | output | 1 | Flash write enable, active low |
| hvOeReq | output | 1 | Request high voltage on the output-enable line |
| hvAddrReq | output | 1 | Request high voltage on the identifier address line |
| flashAddr | output | ADDR_W | Flash address bus |
| flashDqOut | output | 8 | Data driven to the flash |
| flashDqOe | output | 1 | Data bus drive enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed without error |
| err | output | 1 | Run stopped on an error |
| errCode | output | 2 | 0 none, 1 identifier mismatch, 2 erase verify, 3 program verify |
| errAddr | output | ADDR_W | Failing address when err is high |
| idMfr | output | 8 | Manufacturer identifier byte read |
| idDev | output | 8 | Device identifier byte read |

## Verification
The checker watches every cycle for the pin-level safety rules. Pulse widths are checked by the kind of pulse, and the high-voltage requests, address and data must stay steady around each write-enable pulse. The flash must be released whenever the block is not busy, and drive-direction and chip-enable pairing are checked together with the exclusivity of done and err. Only the bench scenarios, run against a flash model, can show that the erase actually clears the array and that each failure class stops the run at the right address with the right code. They also show that a wrong identifier prevents any pulse and that source stalls of random length still program the right bytes in order.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ID_LO, S_ID_HI, S_ER_SET, S_ER_PULSE, S_ER_HOLD, S_EV_READ,
    S_PG_FETCH, S_PG_SET, S_PG_PULSE, S_PG_HOLD, S_PG_VERIFY, S_DONE, S_ERR
  } seq_state_e;

  typedef enum logic [2:0] {
    CNT_SETUP, CNT_HOLD, CNT_READ, CNT_PROG, CNT_ERASE
  } cnt_sel_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_ID = 2'd1, ERR_ERASE = 2'd2, ERR_PROG = 2'd3
  } err_code_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     cntLoad;
    cnt_sel_e cntSel;
    logic     addrClr;
    logic     addrInc;
    logic     srcLatch;
    logic     mfrCap;
    logic     devCap;
  } dp_ctrl_t;

  localparam logic [7:0] MFR_EXPECT  = 8'hBF;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int CNT_W     = 17,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 2,
  parameter int PROG_CYC  = 10,
  parameter int ERASE_CYC = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctl,
  input  logic [7:0]        srcData,
  input  logic [7:0]        flashDqIn,
  output logic [ADDR_W-1:0] addrReg,
  output logic [7:0]        dataReg,
  output logic [7:0]        mfrReg,
  output logic [7:0]        devReg,
  output logic              cntZero,
  output logic              addrLast,
  output logic              rdErased,
  output logic              rdMatch,
  output logic              mfrOk
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    case (ctl.cntSel)
      CNT_SETUP: loadVal = CNT_W'(SETUP_CYC - 1);
      CNT_HOLD:  loadVal = CNT_W'(HOLD_CYC - 1);
      CNT_READ:  loadVal = CNT_W'(READ_CYC - 1);
      CNT_PROG:  loadVal = CNT_W'(PROG_CYC - 1);
      default:   loadVal = CNT_W'(ERASE_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.cntLoad) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (ctl.addrClr) begin
      addrReg <= '0;
    end else if (ctl.addrInc) begin
      addrReg <= addrReg + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      mfrReg  <= '0;
      devReg  <= '0;
    end else begin
      if (ctl.srcLatch) dataReg <= srcData;
      if (ctl.mfrCap)   mfrReg  <= flashDqIn;
      if (ctl.devCap)   devReg  <= flashDqIn;
    end
  end

  assign cntZero  = (cnt == '0);
  assign addrLast = (addrReg == {ADDR_W{1'b1}});
  assign rdErased = (flashDqIn == ERASED_BYTE);
  assign rdMatch  = (flashDqIn == dataReg);
  assign mfrOk    = (mfrReg == MFR_EXPECT);

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       readIdFirst,
  input  logic       srcValid,
  input  logic       cntZero,
  input  logic       addrLast,
  input  logic       rdErased,
  input  logic       rdMatch,
  input  logic       mfrOk,
  output dp_ctrl_t   ctl,
  output logic [1:0] errCode,
  output logic       flashCeN,
  output logic       flashOeN,
  output logic       flashWeN,
  output logic       hvOeReq,
  output logic       hvAddrReq,
  output logic       flashDqOe,
  output logic       srcReq,
  output logic       idMode,
  output logic       idBit,
  output logic       busy,
  output logic       done,
  output logic       err
);

  seq_state_e state, nxt;
  err_code_e  errReg, errNxt;
  logic       errSet, errClr;

  always_comb begin
    nxt        = state;
    ctl        = '0;
    ctl.cntSel = CNT_SETUP;
    errSet     = 1'b0;
    errClr     = 1'b0;
    errNxt     = ERR_NONE;
    case (state)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          errClr      = 1'b1;
          ctl.addrClr = 1'b1;
          ctl.cntLoad = 1'b1;
          if (readIdFirst) begin
            nxt        = S_ID_LO;
            ctl.cntSel = CNT_READ;
          end else begin
            nxt = S_ER_SET;
          end
        end
      end
      S_ID_LO: if (cntZero) begin
        ctl.mfrCap  = 1'b1;
        ctl.cntLoad = 1'b1;
        ctl.cntSel  = CNT_READ;
        nxt         = S_ID_HI;
      end
      S_ID_HI: if (cntZero) begin
        ctl.devCap = 1'b1;
        if (!mfrOk) begin
          nxt    = S_ERR;
          errSet = 1'b1;
          errNxt = ERR_ID;
        end else begin
          ctl.cntLoad = 1'b1;
          nxt         = S_ER_SET;
        end
      end
      S_ER_SET: if (cntZero) begin
        ctl.cntLoad = 1'b1;
        ctl.cntSel  = CNT_ERASE;
        nxt         = S_ER_PULSE;
      end
      S_ER_PULSE: if (cntZero) begin
        ctl.cntLoad = 1'b1;
        ctl.cntSel  = CNT_HOLD;
        nxt         = S_ER_HOLD;
      end
      S_ER_HOLD: if (cntZero) begin
        ctl.cntLoad = 1'b1;
        ctl.cntSel  = CNT_READ;
        ctl.addrClr = 1'b1;
        nxt         = S_EV_READ;
      end
      S_EV_READ: if (cntZero) begin
        if (!rdErased) begin
          nxt    = S_ERR;
          errSet = 1'b1;
          errNxt = ERR_ERASE;
        end else if (addrLast) begin
          ctl.addrClr = 1'b1;
          nxt         = S_PG_FETCH;
        end else begin
          ctl.addrInc = 1'b1;
          ctl.cntLoad = 1'b1;
          ctl.cntSel  = CNT_READ;
        end
      end
      S_PG_FETCH: if (srcValid) begin
        ctl.srcLatch = 1'b1;
        ctl.cntLoad  = 1'b1;
        nxt          = S_PG_SET;
      end
      S_PG_SET: if (cntZero) begin
        ctl.cntLoad = 1'b1;
        ctl.cntSel  = CNT_PROG;
        nxt         = S_PG_PULSE;
      end
      S_PG_PULSE: if (cntZero) begin
        ctl.cntLoad = 1'b1;
        ctl.cntSel  = CNT_HOLD;
        nxt         = S_PG_HOLD;
      end
      S_PG_HOLD: if (cntZero) begin
        ctl.cntLoad = 1'b1;
        ctl.cntSel  = CNT_READ;
        nxt         = S_PG_VERIFY;
      end
      S_PG_VERIFY: if (cntZero) begin
        if (!rdMatch) begin
          nxt    = S_ERR;
          errSet = 1'b1;
          errNxt = ERR_PROG;
        end else if (addrLast) begin
          nxt = S_DONE;
        end else begin
          ctl.addrInc = 1'b1;
          nxt         = S_PG_FETCH;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      errReg <= ERR_NONE;
    end else begin
      state <= nxt;
      if (errClr)      errReg <= ERR_NONE;
      else if (errSet) errReg <= errNxt;
    end
  end

  // pin decode, Moore style from the state register
  always_comb begin
    flashCeN  = 1'b1;
    flashOeN  = 1'b1;
    flashWeN  = 1'b1;
    hvOeReq   = 1'b0;
    hvAddrReq = 1'b0;
    flashDqOe = 1'b0;
    srcReq    = 1'b0;
    idMode    = 1'b0;
    idBit     = 1'b0;
    case (state)
      S_ID_LO, S_ID_HI: begin
        flashCeN  = 1'b0;
        flashOeN  = 1'b0;
        hvAddrReq = 1'b1;
        idMode    = 1'b1;
        idBit     = (state == S_ID_HI);
      end
      S_ER_SET, S_ER_PULSE, S_ER_HOLD: begin
        flashCeN  = 1'b0;
        hvOeReq   = 1'b1;
        hvAddrReq = 1'b1;
        flashWeN  = (state != S_ER_PULSE);
      end
      S_EV_READ, S_PG_VERIFY: begin
        flashCeN = 1'b0;
        flashOeN = 1'b0;
      end
      S_PG_FETCH: srcReq = 1'b1;
      S_PG_SET, S_PG_PULSE, S_PG_HOLD: begin
        flashCeN  = 1'b0;
        hvOeReq   = 1'b1;
        flashDqOe = 1'b1;
        flashWeN  = (state != S_PG_PULSE);
      end
      default: ;
    endcase
  end

  assign busy    = !(state == S_IDLE || state == S_DONE || state == S_ERR);
  assign done    = (state == S_DONE);
  assign err     = (state == S_ERR);
  assign errCode = errReg;

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int CLK_HZ    = 1_000_000,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              readIdFirst,
  input  logic              srcValid,
  input  logic [7:0]        srcData,
  input  logic [7:0]        flashDqIn,
  output logic              srcReq,
  output logic [ADDR_W-1:0] srcAddr,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN,
  output logic              hvOeReq,
  output logic              hvAddrReq,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDqOut,
  output logic              flashDqOe,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        errCode,
  output logic [ADDR_W-1:0] errAddr,
  output logic [7:0]        idMfr,
  output logic [7:0]        idDev
);

  localparam int PROG_RAW  = CLK_HZ / 100_000;
  localparam int ERASE_RAW = CLK_HZ / 10;
  localparam int PROG_CYC  = (PROG_RAW  < 1) ? 1 : PROG_RAW;
  localparam int ERASE_CYC = (ERASE_RAW < 1) ? 1 : ERASE_RAW;
  localparam int SET_C     = (SETUP_CYC < 1) ? 1 : SETUP_CYC;
  localparam int HLD_C     = (HOLD_CYC  < 1) ? 1 : HOLD_CYC;
  localparam int RD_C      = (READ_CYC  < 1) ? 1 : READ_CYC;
  localparam int MAX_A     = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_B     = (SET_C > HLD_C) ? SET_C : HLD_C;
  localparam int MAX_C     = (MAX_B > RD_C) ? MAX_B : RD_C;
  localparam int MAX_CYC   = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  dp_ctrl_t          ctl;
  logic [ADDR_W-1:0] addrReg;
  logic [7:0]        dataReg;
  logic              cntZero, addrLast, rdErased, rdMatch, mfrOk;
  logic              idMode, idBit;

  flash_prog_ctrl u_ctrl (
    .clk, .rstN, .start, .readIdFirst, .srcValid,
    .cntZero, .addrLast, .rdErased, .rdMatch, .mfrOk,
    .ctl, .errCode,
    .flashCeN, .flashOeN, .flashWeN, .hvOeReq, .hvAddrReq, .flashDqOe,
    .srcReq, .idMode, .idBit, .busy, .done, .err
  );

  flash_prog_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SETUP_CYC(SET_C), .HOLD_CYC(HLD_C),
    .READ_CYC(RD_C), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_dp (
    .clk, .rstN, .ctl, .srcData, .flashDqIn,
    .addrReg, .dataReg, .mfrReg(idMfr), .devReg(idDev),
    .cntZero, .addrLast, .rdErased, .rdMatch, .mfrOk
  );

  assign flashAddr  = idMode ? ADDR_W'(idBit) : addrReg;
  assign flashDqOut = dataReg;
  assign srcAddr    = addrReg;
  assign errAddr    = addrReg;

endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int ADDR_W    = 18,
  parameter int PROG_CYC  = 10,
  parameter int ERASE_CYC = 100000
) (
  input logic              clk,
  input logic              rstN,
  input logic              flashCeN,
  input logic              flashOeN,
  input logic              flashWeN,
  input logic              hvOeReq,
  input logic              hvAddrReq,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [7:0]        flashDqOut,
  input logic              flashDqOe,
  input logic              busy,
  input logic              done,
  input logic              err
);

  logic [31:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lowCnt <= '0;
    else if (!flashWeN) lowCnt <= lowCnt + 1'b1;
    else                lowCnt <= '0;
  end

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (flashCeN && flashOeN && flashWeN && !hvOeReq && !hvAddrReq && !flashDqOe));

  assert_erase_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flashWeN) && hvAddrReq) |-> (lowCnt == 32'(ERASE_CYC)));

  assert_hv_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |=> ($stable(hvOeReq) && $stable(hvAddrReq)));

  assert_prog_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flashWeN) && !hvAddrReq) |-> (lowCnt == 32'(PROG_CYC)));

  assert_pulse_has_hv_R5: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> hvOeReq);

  assert_bus_setup_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashWeN) |-> ($stable(flashAddr) && $stable(flashDqOut)));

  assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |=> ($stable(flashAddr) && $stable(flashDqOut)));

  assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  assert_we_needs_ce_R10: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> !flashCeN);

  assert_dq_direction_R10: assert property (@(posedge clk) disable iff (!rstN)
    flashDqOe |-> flashOeN);

endmodule

bind flash_prog_seq flash_prog_chk #(
  .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_chk (.*);

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int CLK_HZ     = 200_000;
  localparam int SETUP_CYC  = 2;
  localparam int HOLD_CYC   = 2;
  localparam int READ_CYC   = 2;
  localparam int PROG_W     = CLK_HZ / 100_000;
  localparam int ERASE_W    = CLK_HZ / 10;
  localparam int WATCHDOG   = 190_000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic readIdFirst = 1'b0;
  logic srcValid = 1'b0;
  logic [7:0] srcData = 8'h00;
  logic [7:0] flashDqIn;
  logic srcReq, flashCeN, flashOeN, flashWeN, hvOeReq, hvAddrReq, flashDqOe;
  logic busy, done, err;
  logic [ADDR_W-1:0] srcAddr, flashAddr, errAddr;
  logic [7:0] flashDqOut, idMfr, idDev;
  logic [1:0] errCode;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_seq #(
    .ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ), .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC(HOLD_CYC), .READ_CYC(READ_CYC)
  ) dut (.*);

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model and fault knobs
  logic [7:0] mem [DEPTH];
  logic [7:0] srcMem [DEPTH];
  logic [7:0] mfrVal = 8'hBF;
  int eraseStuck = -1;
  int progStuck = -1;
  int eraseCount = 0;
  int progCount = 0;

  assign flashDqIn = (!flashCeN && !flashOeN) ?
                     (hvAddrReq ? (flashAddr[0] ? 8'hC5 : mfrVal) : mem[flashAddr]) : 8'h00;

  // pulse monitor
  logic prevWeN = 1'b1;
  int lowCnt = 0;
  int addrAge = 0;
  logic [ADDR_W-1:0] lastAddr = '0;
  logic [ADDR_W-1:0] fallAddr;
  logic [7:0] fallDq;
  logic [1:0] fallHv;

  always @(posedge clk) begin
    if (rstN) begin
      if (flashAddr == lastAddr) addrAge++; else addrAge = 0;
      lastAddr = flashAddr;
      if (!flashWeN) lowCnt++;
      if (prevWeN && !flashWeN) begin
        fallAddr = flashAddr;
        fallDq   = flashDqOut;
        fallHv   = {hvOeReq, hvAddrReq};
        chk(addrAge >= SETUP_CYC, "R6 address setup age", addrAge, SETUP_CYC);
        chk(!flashCeN, "R10 chip enable low at pulse", int'(flashCeN), 0);
      end
      if (!prevWeN && flashWeN) begin
        chk(flashAddr == fallAddr && flashDqOut == fallDq, "R6 bus held over pulse",
            int'(flashAddr), int'(fallAddr));
        chk({hvOeReq, hvAddrReq} == fallHv, "R3 hv flags steady over pulse",
            int'({hvOeReq, hvAddrReq}), int'(fallHv));
        if (fallHv == 2'b11) begin
          chk(lowCnt == ERASE_W, "R3 erase pulse width", lowCnt, ERASE_W);
          for (int i = 0; i < DEPTH; i++) mem[i] = (i == eraseStuck) ? 8'h00 : 8'hFF;
          eraseCount++;
        end else begin
          chk(fallHv == 2'b10, "R5 program hv flags", int'(fallHv), 2);
          chk(lowCnt == PROG_W, "R5 program pulse width", lowCnt, PROG_W);
          mem[fallAddr] = mem[fallAddr] & fallDq;
          if (int'(fallAddr) == progStuck) mem[fallAddr] = mem[fallAddr] | 8'h01;
          progCount++;
        end
        lowCnt = 0;
      end
      prevWeN = flashWeN;
    end
  end

  // byte source with random stall
  int dly = 0;
  always @(negedge clk) begin
    if (srcValid) srcValid = 1'b0;
    else if (srcReq) begin
      if (dly == 0) begin
        srcValid = 1'b1;
        srcData  = srcMem[srcAddr];
        dly      = $urandom % 4;
      end else dly--;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog R8 actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic runSeq(input bit withId);
    eraseCount = 0;
    progCount  = 0;
    @(negedge clk);
    start = 1'b1;
    readIdFirst = withId;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    while (!(done || err)) @(negedge clk);
  endtask

  task automatic chkReleased(input string req);
    chk({flashCeN, flashOeN, flashWeN} == 3'b111, req, int'({flashCeN, flashOeN, flashWeN}), 7);
    chk({hvOeReq, hvAddrReq, flashDqOe, busy} == 4'b0000, req,
        int'({hvOeReq, hvAddrReq, flashDqOe, busy}), 0);
  endtask

  task automatic chkContents(input string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != srcMem[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h5A ^ 8'(i);
    repeat (3) @(negedge clk);
    chkReleased("R1 reset pins");
    chk({done, err} == 2'b00, "R1 reset status", int'({done, err}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkReleased("R1 idle pins");

    // A: full run with identifier read, random data
    for (int i = 0; i < DEPTH; i++) srcMem[i] = 8'($urandom);
    runSeq(1'b1);
    chk(done && !err, "R8 done after good run", int'({done, err}), 2);
    chk(errCode == 2'd0, "R8 errCode zero", int'(errCode), 0);
    chk(idMfr == 8'hBF, "R2 manufacturer byte", int'(idMfr), 'hBF);
    chk(idDev == 8'hC5, "R2 device byte", int'(idDev), 'hC5);
    chk(eraseCount == 1, "R3 one erase pulse", eraseCount, 1);
    chk(progCount == DEPTH, "R5 one pulse per byte", progCount, DEPTH);
    chkContents("R5 programmed contents");
    chkReleased("R1 released after done");

    // B: wrong manufacturer byte
    mfrVal = 8'h12;
    runSeq(1'b1);
    chk(err && !done, "R2 error on id mismatch", int'({done, err}), 1);
    chk(errCode == 2'd1, "R2 errCode id", int'(errCode), 1);
    chk(idMfr == 8'h12, "R2 captured manufacturer", int'(idMfr), 'h12);
    chk(eraseCount + progCount == 0, "R2 no pulse on mismatch", eraseCount + progCount, 0);
    chkReleased("R9 released after error");

    // C: one location fails to erase
    mfrVal = 8'hBF;
    eraseStuck = 5;
    for (int i = 0; i < DEPTH; i++) srcMem[i] = 8'($urandom);
    runSeq(1'b0);
    chk(err, "R4 error on erase verify", int'(err), 1);
    chk(errCode == 2'd2, "R4 errCode erase", int'(errCode), 2);
    chk(errAddr == 4'd5, "R4 failing address", int'(errAddr), 5);
    chk(progCount == 0, "R4 no program pulse", progCount, 0);
    chkReleased("R9 released after erase error");

    // D: stuck bit at address 9
    eraseStuck = -1;
    progStuck = 9;
    for (int i = 0; i < DEPTH; i++) srcMem[i] = 8'($urandom);
    srcMem[9] = srcMem[9] & 8'hFE;
    runSeq(1'b1);
    chk(err && !done, "R7 error on program verify", int'({done, err}), 1);
    chk(errCode == 2'd3, "R7 errCode program", int'(errCode), 3);
    chk(errAddr == 4'd9, "R7 failing address", int'(errAddr), 9);
    chk(progCount == 10, "R7 stop after failing byte", progCount, 10);

    // E: directed all-zero / all-one pattern, no identifier read
    progStuck = -1;
    for (int i = 0; i < DEPTH; i++) srcMem[i] = (i % 2 == 0) ? 8'h00 : 8'hFF;
    runSeq(1'b0);
    chk(done && !err, "R8 done after second run", int'({done, err}), 2);
    chk(errCode == 2'd0, "R8 errCode cleared by start", int'(errCode), 0);
    chk(progCount == DEPTH, "R5 pulse count pattern run", progCount, DEPTH);
    chkContents("R7 pattern contents");
    repeat (3) @(negedge clk);
    chk(done, "R8 done holds", int'(done), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule